// File: doc/BRIEF.md
# Batch-Ready Sample FIFO

This block buffers converter samples in a small first-in first-out store. It raises a data-ready output once a programmable batch size of samples is waiting. A host processor watches that output and then reads exactly one batch. After the ready signal fires, the block holds off any further trigger until the host has taken a full batch of reads. A faster host therefore sees one notice per batch, and not one for every change in occupancy.

A two-bit mode field shapes the ready output. One bit chooses between a held level and a short pulse. The other bit chooses the active polarity. The pulse form lasts for the high half of one conversion-clock period. The level form is meant for single-shot use and works with a batch size of one. The batch size is clamped into the range from one to the store depth. Writes to a full store are dropped and recorded in a sticky flag. Reads from an empty store change nothing.

Top module: `sample_batch_fifo`

## Requirements
- R1: `mode[1]` selects polarity (1 = active high, 0 = active low) and `mode[0]` selects the form (1 = pulse, 0 = level). The inactive level of `data_avail` is the inverse of `mode[1]`.
- R2: When no batch is outstanding, the occupancy is at least the effective batch size and no read is accepted in that cycle, the block fires at that clock edge. The ready output is then active from that edge onward.
- R3: In level form, the ready output goes inactive at the clock edge that accepts the first read after firing. With a batch size of 1 it fires again as soon as a sample is waiting.
- R4: After firing, no new trigger occurs until the host has made as many accepted reads as the batch size latched at the firing edge, however full the store becomes in the meantime.
- R5: In pulse form, the ready output is active only while `clk` is high during the single cycle that follows the firing edge.
- R6: A batch size input of 0 acts as 1. A value above `DEPTH` acts as `DEPTH`.
- R7: Samples leave in arrival order. `rd_data` is registered and loads the head sample at the edge that accepts a read. A read on an empty store leaves `rd_data` and the pointers unchanged.
- R8: A write while the store is full is dropped and sets `overflow`, which stays set until reset.
- R9: While `rst_n` is low at a clock edge, the store empties, `overflow` clears, the batch counter clears and `data_avail` goes to its inactive level.
- R10: `fill` gives the number of stored samples (0 to `DEPTH`). `fifo_empty` is set when `fill` is 0 and `fifo_full` is set when `fill` equals `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; its high phase also gates the pulse |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Bit 1 polarity, bit 0 form (level or pulse) |
| batch_size | input | CW | Requested batch size before clamping |
| wr_stb | input | 1 | Store `wr_data` at this edge |
| wr_data | input | DATA_W | Incoming sample |
| rd_stb | input | 1 | Host read request at this edge |
| rd_data | output | DATA_W | Last sample read out |
| data_avail | output | 1 | Batch-ready signal, shaped by `mode` |
| fill | output | CW | Current occupancy |
| fifo_full | output | 1 | Occupancy equals depth |
| fifo_empty | output | 1 | Occupancy is zero |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
A depth-8 configuration is swept over all four mode settings and batch sizes 0 through 10. The bench compares every output in both clock phases against an arithmetic model. In each run a burst fill finds the exact firing edge. Some runs fill far enough to overflow, which separates dropped writes from stored ones. A mixed write/read stretch then refills the store during an outstanding batch, which separates re-arming on the batch count from re-arming on occupancy. A drain past empty then exposes any pointer motion or data change on empty reads. Sampling in the low phase separates level behaviour from pulse behaviour. The out-of-range batch sizes show whether clamping takes place.

// File: rtl/sbf_pkg.sv
// Package: shared types for the batch-ready sample FIFO.
// Assumes the 2-bit mode field is cast MSB-first into dav_mode_t.
package sbf_pkg;
    typedef struct packed {
        logic active_high;  // 1: ready asserted high
        logic pulse_form;   // 1: half-period pulse, 0: held level
    } dav_mode_t;
endpackage

// File: rtl/sbf_store.sv
// Module: sbf_store
// Circular sample buffer with a registered read port.
// Assumes single-cycle push/pop requests. A push while full is dropped
// and flagged. A pop while empty is ignored. The occupancy counter is the
// single source of truth for full and empty.
module sbf_store #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 16,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic              pop_ok,
    output logic [DATA_W-1:0] dout,
    output logic [CW-1:0]     fill,
    output logic              overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wp, rp;
    logic              push_ok;

    // Accept decisions from current occupancy.
    always_comb begin
        push_ok = push && (fill != FULL_CNT);
        pop_ok  = pop && (fill != '0);
    end

    // Sample storage, written only on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    // Pointers, occupancy, read register and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            fill     <= '0;
            dout     <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wp <= (wp == LAST_IDX) ? '0 : wp + PW'(1);
            if (pop_ok) begin
                rp   <= (rp == LAST_IDX) ? '0 : rp + PW'(1);
                dout <= mem[rp];
            end
            fill <= fill + CW'(push_ok) - CW'(pop_ok);
            if (push && !push_ok) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/sbf_trigger.sv
// Module: sbf_trigger
// Batch trigger: fires when enough samples wait and no batch is
// outstanding. It then counts accepted reads down before re-arming.
// Assumes the batch size is already clamped to 1..DEPTH. A firing is
// held off in a cycle that accepts a read, so each read counts once.
module sbf_trigger #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pulse_form,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] batch_eff,
    input  logic          rd_ok,
    output logic          lvl_q,
    output logic          pls_q
);
    logic [CW-1:0] reads_left;
    logic          fire;

    // Trigger condition: armed, enough samples, no read this cycle.
    always_comb fire = (reads_left == '0) && (fill >= batch_eff) && !rd_ok;

    // Batch counter and output state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads_left <= '0;
            lvl_q      <= 1'b0;
            pls_q      <= 1'b0;
        end else begin
            pls_q <= fire && pulse_form;
            if (fire)                          reads_left <= batch_eff;
            else if (rd_ok && reads_left != '0) reads_left <= reads_left - CW'(1);
            if (fire && !pulse_form) lvl_q <= 1'b1;
            else if (rd_ok)          lvl_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sample_batch_fifo.sv
// Module: sample_batch_fifo (top)
// Sample FIFO with a batch-ready output of selectable polarity and form.
// Assumes clk is the conversion clock. The pulse form is gated with its
// high phase, so the pulse lasts half a period. Mode is expected to stay
// steady outside reset.
module sample_batch_fifo #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 16,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [CW-1:0]     batch_size,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_avail,
    output logic [CW-1:0]     fill,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              overflow
);
    import sbf_pkg::*;

    localparam logic [CW-1:0] MAX_BATCH = CW'(DEPTH);

    dav_mode_t     m;
    logic [CW-1:0] batch_eff;
    logic          rd_ok, lvl_q, pls_q, act;

    // Decode the mode field and clamp the batch size into 1..DEPTH.
    always_comb begin
        m = dav_mode_t'(mode);
        if (batch_size == '0)            batch_eff = CW'(1);
        else if (batch_size > MAX_BATCH) batch_eff = MAX_BATCH;
        else                             batch_eff = batch_size;
    end

    sbf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_stb),
        .din      (wr_data),
        .pop      (rd_stb),
        .pop_ok   (rd_ok),
        .dout     (rd_data),
        .fill     (fill),
        .overflow (overflow)
    );

    sbf_trigger #(.CW(CW)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_form (m.pulse_form),
        .fill       (fill),
        .batch_eff  (batch_eff),
        .rd_ok      (rd_ok),
        .lvl_q      (lvl_q),
        .pls_q      (pls_q)
    );

    // Output shaping: pulse limited to the high phase, then polarity.
    always_comb begin
        act        = lvl_q | (pls_q & clk);
        data_avail = m.active_high ? act : ~act;
        fifo_full  = (fill == MAX_BATCH);
        fifo_empty = (fill == '0);
    end
endmodule

// File: rtl/sbf_checker.sv
// Module: sbf_checker
// Temporal properties of sample_batch_fifo, bound to every instance.
// Assumes mode changes only while rst_n is low.
module sbf_checker #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 16,
    parameter int CW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              data_avail,
    input logic [CW-1:0]     fill,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              overflow,
    input logic              pls_q
);
    assert_reset_state_R9: assert property (@(posedge clk)
        !rst_n |=> (fifo_empty && !overflow && fill == '0));

    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_stb && !rd_stb) |=> (fifo_full && overflow));

    assert_empty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && rd_stb) |=> $stable(rd_data));

    assert_level_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[0] && rd_stb && !fifo_empty) |=> (data_avail == !mode[1]));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pls_q |=> !pls_q);

    assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill <= CW'(DEPTH)) && (fifo_empty == (fill == '0)));
endmodule

bind sample_batch_fifo sbf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .wr_stb     (wr_stb),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .data_avail (data_avail),
    .fill       (fill),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .overflow   (overflow),
    .pls_q      (pls_q)
);

// File: tb/sim_sample_batch_fifo.sv
// Bench: sweeps all modes and batch sizes 0..D+2 on a depth-8 instance,
// comparing every output in both clock phases with an arithmetic model.
module sim_sample_batch_fifo;
    localparam int PERIOD = 10;
    localparam int D      = 8;
    localparam int W      = 10;
    localparam int CW     = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [CW-1:0] batch_size = '0;
    logic          wr_stb = 1'b0, rd_stb = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic          data_avail, fifo_full, fifo_empty, overflow;
    logic [CW-1:0] fill;

    int checks = 0;
    int errors = 0;

    // model state
    logic [W-1:0] mq[$];
    logic [W-1:0] m_rd;
    int  m_batch, tle;
    bit  m_lvl, m_pls, m_ovf, fired;
    logic [15:0] lfsr = 16'hACE1;

    sample_batch_fifo #(.DATA_W(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .batch_size(batch_size),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
        .rd_data(rd_data), .data_avail(data_avail), .fill(fill),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Ready-signal tag chosen by what the current cycle exercises.
    function automatic string avail_tag(int tl_in);
        if (tl_in != tle) return "R6";
        if (fired)        return "R2";
        if (m_batch > 0)  return "R4";
        return mode[0] ? "R5" : "R3";
    endfunction

    // One clock: drive at current (low) phase, model the edge, check both phases.
    task automatic cyc(input bit w, input bit r);
        bit rok, wok, act;
        wr_stb  = w;
        rd_stb  = r;
        wr_data = wr_data + W'(1);
        @(posedge clk);
        rok   = r && mq.size() > 0;
        wok   = w && mq.size() < D;
        fired = (m_batch == 0) && (mq.size() >= tle) && !rok;
        if (rok) m_rd = mq.pop_front();
        if (wok) mq.push_back(wr_data);
        else if (w) m_ovf = 1;
        m_pls = fired && mode[0];
        if (fired) m_batch = tle;
        else if (rok && m_batch > 0) m_batch--;
        if (fired && !mode[0]) m_lvl = 1;
        else if (rok) m_lvl = 0;
        #1;
        act = m_lvl | m_pls;
        chk(avail_tag(int'(batch_size)), data_avail, mode[1] ? act : !act);
        chk("R7", rd_data, m_rd);
        chk("R8", overflow, m_ovf);
        chk("R10", fill, mq.size());
        chk("R10", fifo_full, mq.size() == D);
        chk("R10", fifo_empty, mq.size() == 0);
        @(negedge clk);
        #1;
        chk("R1", data_avail, mode[1] ? m_lvl : !m_lvl);
    endtask

    task automatic do_reset(input logic [1:0] md, input int tl);
        rst_n = 1'b0;
        mode = md;
        batch_size = CW'(tl);
        wr_stb = 0; rd_stb = 0;
        repeat (2) @(posedge clk);
        #1;
        chk("R9", data_avail, !md[1]);
        chk("R9", fifo_empty, 1);
        chk("R9", overflow, 0);
        chk("R9", rd_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        m_rd = '0; m_batch = 0; m_lvl = 0; m_pls = 0; m_ovf = 0; fired = 0;
        tle = (tl == 0) ? 1 : (tl > D) ? D : tl;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int md = 0; md < 4; md++) begin
            for (int tl = 0; tl <= D + 2; tl++) begin
                do_reset(2'(md), tl);
                // burst fill; odd sizes run past full to overflow
                for (int k = 0; k < ((tl % 2) ? D + 2 : tle + 1); k++) cyc(1, 0);
                // mixed traffic, refilling during outstanding batches
                for (int k = 0; k < 40; k++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    cyc(lfsr[0], lfsr[1] | lfsr[2]);
                end
                // drain past empty
                for (int k = 0; k < D + 3; k++) cyc(0, 1);
                // refill then read one batch slowly
                for (int k = 0; k < D + 1; k++) cyc(1, 0);
                for (int k = 0; k < D + 3; k++) cyc(0, k % 2 == 0);
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule